// File: doc/BRIEF.md
# Dual-Mode AXI Burst Memory Slave

This block is an AXI slave that fronts a word-wide on-chip memory and answers incrementing bursts on the AW, W, B, AR and R channels. One input, `beat_mode`, chooses when the memory is touched during a burst.

In burst-buffered mode (`beat_mode` = 0), the read side copies every word of a read burst into a local buffer before the first R beat is offered. The write side collects each accepted W beat in a buffer and commits the whole burst to memory after the last beat. In per-beat mode (`beat_mode` = 1), each R beat is fetched from memory just before it is presented, and each W beat lands in memory on its own handshake.

A read that overlaps a write to the same addresses can therefore return old data, new data or a mix of the two, depending on the mode. Verification environments use the block to exercise a master against both memory-update timings.

Beats are always 4 bytes wide. Byte addresses advance by 4 on each beat and wrap at the end of the memory. One burst is in flight per direction, and IDs are echoed back.

Top module: `axi_dm_mem`

## Requirements
- R1: `beat_mode` = 0 selects burst-buffered behaviour and 1 selects per-beat behaviour. The value is sampled at the AW handshake for a write burst and at the AR handshake for a read burst. Changing `beat_mode` during a burst has no effect on that burst.
- R2: In burst-buffered mode, all words of a read burst are fetched before the first R beat. Writes completed after the AR handshake do not change the data that burst returns.
- R3: In burst-buffered mode, memory is unchanged while a write burst is incomplete. All its beats are committed after the beat with `wlast` = 1 is accepted.
- R4: In per-beat mode, each R beat carries the memory word as it stood when that beat was fetched. The fetch happens in the cycle before `rvalid` rises for that beat. A later beat therefore reflects writes that completed while earlier beats were pending.
- R5: In per-beat mode, each accepted W beat is written to memory at its handshake. A read issued afterwards sees it, even if the burst is not yet complete.
- R6: `bvalid` stays low until the beat with `wlast` = 1 has been accepted. In burst-buffered mode it also stays low until the commit to memory is done. `bresp` is OKAY (2'b00) for a good burst, and `bvalid`, `bresp` and `bid` hold until `bready`.
- R7: A burst with a length field above 15 (more than 16 beats) gets SLVERR (2'b10). A write burst of that length gets it on B and leaves memory unchanged. A read burst of that length returns len+1 beats, each with SLVERR and zero data.
- R8: On commit, `wstrb` bit i enables byte lane i, which is data bits 8i+7 to 8i. Lanes whose strobe bit is 0 keep their old content. This applies in both modes.
- R9: Beat k of a burst accesses byte address start + 4k, wrapping at the memory size. `rlast` is 1 on the final beat only, and R outputs hold while `rvalid` is high and `rready` is low.
- R10: After reset, `awready` and `arready` are 1 and `bvalid` and `rvalid` are 0.
- R11: Each direction takes one burst at a time. `awready` is 0 from the AW handshake until the B handshake, and `arready` is 0 from the AR handshake until the last R handshake.
- R12: `bid` returns the burst's `awid`, and `rid` returns the burst's `arid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_mode | input | 1 | 0 = burst-buffered, 1 = per-beat |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awid | input | ID_W | Write ID |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte lane enables |
| wlast | input | 1 | Final write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| bid | output | ID_W | Write response ID |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arid | input | ID_W | Read ID |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat |
| rid | output | ID_W | Read ID |

## Verification
The central pattern runs a read burst against a write burst to the same words, in each mode.

In the first case, the AR handshake is taken with `rready` held low and a write is completed before the beats are drained. Burst-buffered mode must return all old words. Per-beat mode must return the old first word and new later words.

In the second case, a write burst is paused halfway and the words are read back. Per-beat mode must show the first half already written, and burst-buffered mode must show nothing changed.

Flipping `beat_mode` after the AR handshake shows that the mode is latched per burst. Partial strobes, over-long bursts and a burst that crosses the top of the memory cover the lane masking, the error path and the address wrap.

// File: rtl/axi_dm_pkg.sv
package axi_dm_pkg;
  typedef enum logic {
    MODE_BURST = 1'b0,
    MODE_BEAT  = 1'b1
  } xfer_mode_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axi_dm_ram.sv
// Simple dual-port word memory with byte enables, read-first, registered read.
module axi_dm_ram #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(WORDS)-1:0]   waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W/8-1:0]        wstrb,
  input  logic                       re,
  input  logic [$clog2(WORDS)-1:0]   raddr,
  output logic [DATA_W-1:0]          rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (wstrb[b]) store[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/axi_dm_wr_engine.sv
// Write side: AW/W/B handling, burst buffer and memory write port control.
module axi_dm_wr_engine
  import axi_dm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MAX_BEATS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat_mode,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic [7:0]           awlen,
  input  logic [ID_W-1:0]      awid,
  input  logic                 wvalid,
  output logic                 wready,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W/8-1:0]  wstrb,
  input  logic                 wlast,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [1:0]           bresp,
  output logic [ID_W-1:0]      bid,
  output logic                 mem_we,
  output logic [ADDR_W-3:0]    mem_waddr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [DATA_W/8-1:0]  mem_wstrb
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int BIDX_W = $clog2(MAX_BEATS);
  localparam int STRB_W = DATA_W / 8;

  typedef enum logic [1:0] {W_IDLE, W_DATA, W_COMMIT, W_RESP} wr_state_e;

  wr_state_e          st;
  xfer_mode_e         mode_q;
  logic               err_q;
  logic [IDX_W-1:0]   base_q;
  logic [ID_W-1:0]    id_q;
  logic [7:0]         beat_q;
  logic [BIDX_W-1:0]  cnt_q;

  logic [DATA_W-1:0]  wbuf_d [MAX_BEATS];
  logic [STRB_W-1:0]  wbuf_s [MAX_BEATS];

  logic unused_lo;
  assign unused_lo = &{1'b0, awaddr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= W_IDLE;
      mode_q <= MODE_BURST;
      err_q  <= 1'b0;
      base_q <= '0;
      id_q   <= '0;
      beat_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st)
        W_IDLE: if (awvalid) begin
          base_q <= awaddr[2 +: IDX_W];
          id_q   <= awid;
          mode_q <= beat_mode ? MODE_BEAT : MODE_BURST;
          err_q  <= (awlen > 8'(MAX_BEATS - 1));
          beat_q <= '0;
          st     <= W_DATA;
        end
        W_DATA: if (wvalid) begin
          if (wlast) begin
            cnt_q <= '0;
            st    <= (!err_q && mode_q == MODE_BURST) ? W_COMMIT : W_RESP;
          end else begin
            beat_q <= beat_q + 8'd1;
          end
        end
        W_COMMIT: begin
          if (cnt_q == beat_q[BIDX_W-1:0]) st <= W_RESP;
          else cnt_q <= cnt_q + 1'b1;
        end
        W_RESP: if (bready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  // Burst buffer: plain register file, no reset needed
  always_ff @(posedge clk) begin
    if (st == W_DATA && wvalid && !err_q) begin
      wbuf_d[beat_q[BIDX_W-1:0]] <= wdata;
      wbuf_s[beat_q[BIDX_W-1:0]] <= wstrb;
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = base_q + IDX_W'(beat_q);
    mem_wdata = wdata;
    mem_wstrb = wstrb;
    if (st == W_COMMIT) begin
      mem_we    = 1'b1;
      mem_waddr = base_q + IDX_W'(cnt_q);
      mem_wdata = wbuf_d[cnt_q];
      mem_wstrb = wbuf_s[cnt_q];
    end else if (st == W_DATA && wvalid && !err_q && mode_q == MODE_BEAT) begin
      mem_we = 1'b1;
    end
  end

  assign awready = (st == W_IDLE);
  assign wready  = (st == W_DATA);
  assign bvalid  = (st == W_RESP);
  assign bresp   = err_q ? RESP_SLVERR : RESP_OKAY;
  assign bid     = id_q;

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> (bvalid && $stable(bresp) && $stable(bid))); // R6
  AST_AW_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bvalid || wready) |-> !awready); // R11
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (wready && mode_q == MODE_BURST) |-> !mem_we); // R3
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (err_q && !awready) |-> !mem_we); // R7
endmodule

// File: rtl/axi_dm_rd_engine.sv
// Read side: AR/R handling, prefetch buffer and memory read port control.
module axi_dm_rd_engine
  import axi_dm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MAX_BEATS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat_mode,
  input  logic                 arvalid,
  output logic                 arready,
  input  logic [ADDR_W-1:0]    araddr,
  input  logic [7:0]           arlen,
  input  logic [ID_W-1:0]      arid,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [DATA_W-1:0]    rdata,
  output logic [1:0]           rresp,
  output logic                 rlast,
  output logic [ID_W-1:0]      rid,
  output logic                 mem_re,
  output logic [ADDR_W-3:0]    mem_raddr,
  input  logic [DATA_W-1:0]    mem_rdata
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int BIDX_W = $clog2(MAX_BEATS);
  localparam int CNT_W  = BIDX_W + 1;

  typedef enum logic [1:0] {R_IDLE, R_FETCH, R_PREP, R_SEND} rd_state_e;

  rd_state_e          st;
  xfer_mode_e         mode_q;
  logic               err_q;
  logic [IDX_W-1:0]   base_q;
  logic [ID_W-1:0]    id_q;
  logic [7:0]         len_q;
  logic [7:0]         beat_q;
  logic [CNT_W-1:0]   k_q;
  logic [CNT_W-1:0]   fetch_end;

  logic [DATA_W-1:0]  rbuf [MAX_BEATS];

  logic unused_lo;
  assign unused_lo = &{1'b0, araddr[1:0]};

  assign fetch_end = CNT_W'(len_q[BIDX_W-1:0]) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= R_IDLE;
      mode_q <= MODE_BURST;
      err_q  <= 1'b0;
      base_q <= '0;
      id_q   <= '0;
      len_q  <= '0;
      beat_q <= '0;
      k_q    <= '0;
    end else begin
      case (st)
        R_IDLE: if (arvalid) begin
          base_q <= araddr[2 +: IDX_W];
          id_q   <= arid;
          len_q  <= arlen;
          mode_q <= beat_mode ? MODE_BEAT : MODE_BURST;
          err_q  <= (arlen > 8'(MAX_BEATS - 1));
          beat_q <= '0;
          k_q    <= '0;
          if (arlen > 8'(MAX_BEATS - 1)) st <= R_SEND;
          else if (beat_mode)            st <= R_PREP;
          else                           st <= R_FETCH;
        end
        R_FETCH: begin
          k_q <= k_q + 1'b1;
          if (k_q == fetch_end) st <= R_SEND;
        end
        R_PREP: st <= R_SEND;
        R_SEND: if (rready) begin
          if (beat_q == len_q) begin
            st <= R_IDLE;
          end else begin
            beat_q <= beat_q + 8'd1;
            st     <= (mode_q == MODE_BEAT && !err_q) ? R_PREP : R_SEND;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // Prefetch buffer: capture the word requested one cycle earlier
  always_ff @(posedge clk) begin
    if (st == R_FETCH && k_q != '0) rbuf[BIDX_W'(k_q - 1'b1)] <= mem_rdata;
  end

  always_comb begin
    mem_re    = 1'b0;
    mem_raddr = base_q + IDX_W'(beat_q);
    if (st == R_FETCH) begin
      mem_re    = (k_q != fetch_end);
      mem_raddr = base_q + IDX_W'(k_q);
    end else if (st == R_PREP) begin
      mem_re = 1'b1;
    end
  end

  assign arready = (st == R_IDLE);
  assign rvalid  = (st == R_SEND);
  assign rlast   = rvalid && (beat_q == len_q);
  assign rresp   = err_q ? RESP_SLVERR : RESP_OKAY;
  assign rid     = id_q;
  assign rdata   = err_q ? '0 :
                   (mode_q == MODE_BEAT) ? mem_rdata : rbuf[beat_q[BIDX_W-1:0]];

  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rlast) && $stable(rid))); // R9
  AST_RLAST_VALID: assert property (@(posedge clk) disable iff (rst)
    rlast |-> rvalid); // R9
  AST_AR_BUSY: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !arready); // R11
  AST_ERR_DATA: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rresp == RESP_SLVERR) |-> (rdata == '0)); // R7
endmodule

// File: rtl/axi_dm_mem.sv
module axi_dm_mem
  import axi_dm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int MAX_BEATS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat_mode,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic [7:0]           awlen,
  input  logic [ID_W-1:0]      awid,
  input  logic                 wvalid,
  output logic                 wready,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W/8-1:0]  wstrb,
  input  logic                 wlast,
  output logic                 bvalid,
  input  logic                 bready,
  output logic [1:0]           bresp,
  output logic [ID_W-1:0]      bid,
  input  logic                 arvalid,
  output logic                 arready,
  input  logic [ADDR_W-1:0]    araddr,
  input  logic [7:0]           arlen,
  input  logic [ID_W-1:0]      arid,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [DATA_W-1:0]    rdata,
  output logic [1:0]           rresp,
  output logic                 rlast,
  output logic [ID_W-1:0]      rid
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int WORDS = 2 ** IDX_W;

  logic                 m_we;
  logic [IDX_W-1:0]     m_waddr;
  logic [DATA_W-1:0]    m_wdata;
  logic [DATA_W/8-1:0]  m_wstrb;
  logic                 m_re;
  logic [IDX_W-1:0]     m_raddr;
  logic [DATA_W-1:0]    m_rdata;

  axi_dm_wr_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MAX_BEATS(MAX_BEATS)
  ) u_wr (
    .clk(clk), .rst(rst), .beat_mode(beat_mode),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen), .awid(awid),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bresp(bresp), .bid(bid),
    .mem_we(m_we), .mem_waddr(m_waddr), .mem_wdata(m_wdata), .mem_wstrb(m_wstrb)
  );

  axi_dm_rd_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MAX_BEATS(MAX_BEATS)
  ) u_rd (
    .clk(clk), .rst(rst), .beat_mode(beat_mode),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen), .arid(arid),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rid(rid),
    .mem_re(m_re), .mem_raddr(m_raddr), .mem_rdata(m_rdata)
  );

  axi_dm_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata), .wstrb(m_wstrb),
    .re(m_re), .raddr(m_raddr), .rdata(m_rdata)
  );

  AST_RESP_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !m_we); // R6
endmodule

// File: tb/axi_dm_mem_test.sv
`timescale 1ns/1ps
module axi_dm_mem_test;
  localparam int ADDR_W = 10;
  localparam int ID_W   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic beat_mode = 1'b0;
  logic awvalid = 1'b0, awready;
  logic [ADDR_W-1:0] awaddr = '0;
  logic [7:0] awlen = '0;
  logic [ID_W-1:0] awid = '0;
  logic wvalid = 1'b0, wready;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic wlast = 1'b0;
  logic bvalid, bready = 1'b0;
  logic [1:0] bresp;
  logic [ID_W-1:0] bid;
  logic arvalid = 1'b0, arready;
  logic [ADDR_W-1:0] araddr = '0;
  logic [7:0] arlen = '0;
  logic [ID_W-1:0] arid = '0;
  logic rvalid, rready = 1'b0;
  logic [31:0] rdata;
  logic [1:0] rresp;
  logic rlast;
  logic [ID_W-1:0] rid;

  axi_dm_mem #(.ADDR_W(ADDR_W), .ID_W(ID_W)) uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] rd_d [32];
  logic [1:0]  rd_r [32];
  logic        rd_l [32];
  logic [ID_W-1:0] rd_id [32];
  logic [1:0]  b_r;
  logic [ID_W-1:0] b_id;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic aw_put(logic [ADDR_W-1:0] a, logic [7:0] len, logic [ID_W-1:0] id);
    @(negedge clk); awaddr = a; awlen = len; awid = id; awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk); awvalid = 1'b0;
  endtask

  task automatic w_put(logic [31:0] d, logic [3:0] s, logic last);
    @(negedge clk); wdata = d; wstrb = s; wlast = last; wvalid = 1'b1;
    while (!wready) @(negedge clk);
    @(negedge clk); wvalid = 1'b0; wlast = 1'b0;
  endtask

  task automatic b_get();
    @(negedge clk); bready = 1'b1;
    while (!bvalid) @(negedge clk);
    b_r = bresp; b_id = bid;
    @(negedge clk); bready = 1'b0;
  endtask

  task automatic ar_put(logic [ADDR_W-1:0] a, logic [7:0] len, logic [ID_W-1:0] id);
    @(negedge clk); araddr = a; arlen = len; arid = id; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk); arvalid = 1'b0;
  endtask

  task automatic r_get(int n);
    @(negedge clk); rready = 1'b1;
    for (int i = 0; i < n; i++) begin
      while (!rvalid) @(negedge clk);
      rd_d[i] = rdata; rd_r[i] = rresp; rd_l[i] = rlast; rd_id[i] = rid;
      @(negedge clk);
    end
    rready = 1'b0;
  endtask

  task automatic write_burst(logic [ADDR_W-1:0] a, int n, logic [31:0] seed, logic [3:0] s,
                             logic [ID_W-1:0] id);
    aw_put(a, 8'(n - 1), id);
    for (int k = 0; k < n; k++) w_put(seed + 32'(k), s, k == n - 1);
    b_get();
  endtask

  task automatic read_burst(logic [ADDR_W-1:0] a, int n, logic [ID_W-1:0] id);
    ar_put(a, 8'(n - 1), id);
    r_get(n);
  endtask

  task automatic t_reset();
    chk("R10", "awready", 32'(awready), 32'd1);
    chk("R10", "arready", 32'(arready), 32'd1);
    chk("R10", "bvalid", 32'(bvalid), 32'd0);
    chk("R10", "rvalid", 32'(rvalid), 32'd0);
  endtask

  task automatic t_incr(logic m);
    logic [31:0] seed;
    seed = m ? 32'hB000_0000 : 32'hA000_0000;
    beat_mode = m;
    write_burst(10'h040, 8, seed, 4'hF, 4'h3);
    chk("R6", "bresp okay", 32'(b_r), 32'd0);
    chk("R12", "bid", 32'(b_id), 32'h3);
    read_burst(10'h040, 8, 4'h5);
    for (int k = 0; k < 8; k++) begin
      chk("R9", "incr data", rd_d[k], seed + 32'(k));
      chk("R9", "rlast", 32'(rd_l[k]), 32'(k == 7));
      chk("R12", "rid", 32'(rd_id[k]), 32'h5);
    end
  endtask

  task automatic t_strobe();
    beat_mode = 1'b0;
    write_burst(10'h100, 1, 32'h1122_3344, 4'hF, 4'h1);
    write_burst(10'h100, 1, 32'hAABB_CCDD, 4'b0101, 4'h1);
    read_burst(10'h100, 1, 4'h1);
    chk("R8", "strobe buffered", rd_d[0], 32'h11BB_33DD);
    beat_mode = 1'b1;
    write_burst(10'h100, 1, 32'h5566_7788, 4'b1010, 4'h1);
    read_burst(10'h100, 1, 4'h1);
    chk("R8", "strobe per-beat", rd_d[0], 32'h55BB_77DD);
  endtask

  // Write paused mid-burst, then read back: separates R3 from R5
  task automatic t_wr_defer(logic m);
    beat_mode = 1'b1;
    write_burst(10'h200, 4, 32'h1000, 4'hF, 4'h0);
    beat_mode = m;
    aw_put(10'h200, 8'd3, 4'h6);
    w_put(32'h2000, 4'hF, 1'b0);
    w_put(32'h2001, 4'hF, 1'b0);
    repeat (5) @(negedge clk);
    chk("R6", "no bvalid before wlast", 32'(bvalid), 32'd0);
    chk("R11", "awready low mid-burst", 32'(awready), 32'd0);
    read_burst(10'h200, 4, 4'h2);
    for (int k = 0; k < 4; k++) begin
      if (m) chk("R5", "per-beat write visible", rd_d[k], (k < 2) ? 32'h2000 + 32'(k) : 32'h1000 + 32'(k));
      else   chk("R3", "buffered write deferred", rd_d[k], 32'h1000 + 32'(k));
    end
    w_put(32'h2002, 4'hF, 1'b0);
    w_put(32'h2003, 4'hF, 1'b1);
    b_get();
    chk("R12", "bid deferred", 32'(b_id), 32'h6);
    read_burst(10'h200, 4, 4'h2);
    for (int k = 0; k < 4; k++) chk(m ? "R5" : "R3", "after B", rd_d[k], 32'h2000 + 32'(k));
  endtask

  // Read accepted, write completes before beats drain: separates R2 from R4
  task automatic t_rd_overlap(logic m);
    beat_mode = 1'b1;
    write_burst(10'h300, 4, 32'h3000, 4'hF, 4'h0);
    beat_mode = m;
    ar_put(10'h300, 8'd3, 4'h9);
    if (!m) beat_mode = 1'b1;  // R1: change after AR must not affect this burst
    repeat (10) @(negedge clk);
    chk("R11", "arready low during read", 32'(arready), 32'd0);
    write_burst(10'h300, 4, 32'h4000, 4'hF, 4'h0);
    r_get(4);
    for (int k = 0; k < 4; k++) begin
      if (m) chk("R4", "per-beat read", rd_d[k], (k == 0) ? 32'h3000 : 32'h4000 + 32'(k));
      else   chk("R2", "snapshot read (R1 mode latched)", rd_d[k], 32'h3000 + 32'(k));
    end
  endtask

  task automatic t_err(logic m);
    beat_mode = 1'b1;
    write_burst(10'h180, 1, 32'h5A5A_0000, 4'hF, 4'h0);
    beat_mode = m;
    write_burst(10'h180, 17, 32'hDEAD_0000, 4'hF, 4'h4);
    chk("R7", "long write SLVERR", 32'(b_r), 32'd2);
    read_burst(10'h180, 1, 4'h0);
    chk("R7", "memory untouched", rd_d[0], 32'h5A5A_0000);
    read_burst(10'h180, 17, 4'h7);
    for (int k = 0; k < 17; k++) begin
      chk("R7", "long read resp", 32'(rd_r[k]), 32'd2);
      chk("R7", "long read data", rd_d[k], 32'd0);
      chk("R9", "long read rlast", 32'(rd_l[k]), 32'(k == 16));
    end
  endtask

  task automatic t_wrap();
    beat_mode = 1'b0;
    write_burst(10'h3F8, 4, 32'h7700, 4'hF, 4'h0);
    read_burst(10'h000, 2, 4'h0);
    chk("R9", "wrap word0", rd_d[0], 32'h7702);
    chk("R9", "wrap word1", rd_d[1], 32'h7703);
    read_burst(10'h3F8, 4, 4'h0);
    for (int k = 0; k < 4; k++) chk("R9", "wrap read", rd_d[k], 32'h7700 + 32'(k));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_incr(1'b0);
    t_incr(1'b1);
    t_strobe();
    t_wr_defer(1'b0);
    t_wr_defer(1'b1);
    t_rd_overlap(1'b0);
    t_rd_overlap(1'b1);
    t_err(1'b0);
    t_err(1'b1);
    t_wrap();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule